// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This unit works on one contiguous bit field of a 32-bit word. The field is chosen through one of two stored descriptors. Each descriptor holds a 5-bit offset, which is the position of the field's lowest bit. It also holds a 5-bit width code, and the field width is the code plus one.

A configure operation loads the selected descriptor. After that, the other operations use it:
- **insert** places the low bits of the source into the field of the destination.
- **extract** returns the field of the source, zero-extended.
- **two rotate-extract forms** shift the destination by the field width and fill the vacated bits with the extracted field.

Both descriptors reset to byte lanes. The unit can therefore be used before any configure operation.

Each request is a single-cycle strobe carrying an opcode, a descriptor select and two operand words. The result appears registered one clock later, together with an output strobe. A configure operation affects only requests that arrive after it.

Top module: `bitfield_unit`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o is 0 and result_o is 0. Descriptor A resets to offset 0, width code 7 (bits 7..0). Descriptor B resets to offset 8, width code 7 (bits 15..8).
- R2: valid_o equals valid_i of the previous cycle. result_o changes only on a clock edge where valid_i was 1, and otherwise holds its value.
- R3: The configure opcode (op_i = 0) loads offset = dst_i[4:0] and width code = src_i[4:0] into the selected descriptor, and returns a result of 0. The new values govern requests from the next cycle onward.
- R4: The field width is the width code plus 1. Code 0 gives a 1-bit field and code 31 gives a full 32-bit field.
- R5: Extract (op_i = 2) returns (src_i >> offset) masked to the field width, with all higher bits 0.
- R6: Insert (op_i = 1) returns dst_i with the field bits replaced by (src_i << offset) restricted to the field. All bits outside the field equal dst_i.
- R7: When offset + width exceeds 32, the field stops at bit 31. Insert writes nothing to the low bits, and extract returns only the bits up to bit 31.
- R8: Rotate-left extract (op_i = 3) returns dst_i rotated left by the width, with its low width bits replaced by the extracted field.
- R9: Rotate-right extract (op_i = 4) returns dst_i rotated right by the width, with its top width bits replaced by the extracted field.
- R10: sel_i = 0 selects descriptor A and sel_i = 1 selects descriptor B. Configuring one descriptor leaves the other unchanged.
- R11: Opcodes 5 to 7 return dst_i unchanged and alter neither descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Opcode: 0 configure, 1 insert, 2 extract, 3 rotate-left extract, 4 rotate-right extract |
| sel_i | input | 1 | Descriptor select: 0 is A, 1 is B |
| dst_i | input | 32 | Destination operand; its bits 4..0 carry the offset on configure |
| src_i | input | 32 | Source operand; its bits 4..0 carry the width code on configure |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 32 | Registered result |

## Verification
Operands are chosen so that every hex digit in the result is distinct. This makes an offset that is off by one, or a width that is off by one, change the value that is checked. Each descriptor is tested with its reset layout and with reconfigured layouts, so that a mix-up between A and B shows up.

The width extremes (1 bit and 32 bits) are run through extract, insert and both rotations. At 32 bits the rotation amount equals the word size, and at 1 bit the field sits at bit 31. A field that runs past bit 31 separates truncation from wraparound.

Reserved opcodes are followed by an extract. That extract exposes any unintended change to a descriptor.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [2:0] {
    OP_CFG = 3'd0,
    OP_SET = 3'd1,
    OP_GET = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4
  } bfu_op_e;
endpackage

// File: rtl/bfu_desc_regs.sv
module bfu_desc_regs #(
  parameter int unsigned OFF_W    = 5,
  parameter int unsigned NUM_DESC = 2,
  parameter int unsigned SEL_W    = 1,
  parameter logic [NUM_DESC*OFF_W-1:0] RST_OFFS = {5'd8, 5'd0},
  parameter logic [NUM_DESC*OFF_W-1:0] RST_WCS  = {5'd7, 5'd7}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] wc_i,
  output logic [OFF_W-1:0] off_o,
  output logic [OFF_W-1:0] wc_o
);
  logic [OFF_W-1:0] off_q [NUM_DESC];
  logic [OFF_W-1:0] wc_q  [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q[g] <= RST_OFFS[g*OFF_W +: OFF_W];
        wc_q[g]  <= RST_WCS[g*OFF_W +: OFF_W];
      end else if (we_i && (sel_i == SEL_W'(g))) begin
        off_q[g] <= off_i;
        wc_q[g]  <= wc_i;
      end
    end
  end

  assign off_o = off_q[sel_i];
  assign wc_o  = wc_q[sel_i];
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [OFF_W-1:0]  wc_i,
  output logic [OFF_W:0]    width_o,
  output logic [DATA_W-1:0] low_mask_o,
  output logic [DATA_W-1:0] field_mask_o
);
  logic [OFF_W+1:0] top_excl;

  assign width_o  = {1'b0, wc_i} + (OFF_W+1)'(1);
  // top_excl may exceed DATA_W; bits above the word simply do not exist
  assign top_excl = {2'b00, off_i} + {1'b0, width_o};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign low_mask_o[i]   = ((OFF_W+1)'(i) < width_o);
    assign field_mask_o[i] = ((OFF_W+2)'(i) >= {2'b00, off_i}) &&
                             ((OFF_W+2)'(i) < top_excl);
  end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [OFF_W:0]    width_i,
  input  logic [DATA_W-1:0] low_mask_i,
  input  logic [DATA_W-1:0] field_mask_i,
  output logic [DATA_W-1:0] result_o
);
  logic [OFF_W:0]    rem;
  logic [DATA_W-1:0] field, rotl, rotr, hi_mask, ins, rol_res, ror_res;

  assign rem     = (OFF_W+1)'(DATA_W) - width_i;
  assign field   = (src_i >> off_i) & low_mask_i;
  // shifts of DATA_W yield zero, so width == DATA_W degenerates to no rotation
  assign rotl    = (dst_i << width_i) | (dst_i >> rem);
  assign rotr    = (dst_i >> width_i) | (dst_i << rem);
  assign hi_mask = ~({DATA_W{1'b1}} >> width_i);
  assign ins     = (dst_i & ~field_mask_i) | ((src_i << off_i) & field_mask_i);
  assign rol_res = (rotl & ~low_mask_i) | field;
  assign ror_res = (rotr & ~hi_mask) | (field << rem);

  always_comb begin
    unique case (op_i)
      OP_CFG:  result_o = '0;
      OP_SET:  result_o = ins;
      OP_GET:  result_o = field;
      OP_ROL:  result_o = rol_res;
      OP_ROR:  result_o = ror_res;
      default: result_o = dst_i;
    endcase
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_DESC = 2,
  parameter int unsigned OFF_W    = $clog2(DATA_W),
  parameter int unsigned SEL_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  parameter logic [NUM_DESC*OFF_W-1:0] RST_OFFS = {5'd8, 5'd0},
  parameter logic [NUM_DESC*OFF_W-1:0] RST_WCS  = {5'd7, 5'd7}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic [OFF_W-1:0]  cur_off, cur_wc;
  logic [OFF_W:0]    cur_width;
  logic [DATA_W-1:0] sel_low_mask, sel_field_mask, res_d, res_q;
  logic              cfg_we, valid_q;

  assign cfg_we = valid_i && (op_i == OP_CFG);

  bfu_desc_regs #(
    .OFF_W(OFF_W), .NUM_DESC(NUM_DESC), .SEL_W(SEL_W),
    .RST_OFFS(RST_OFFS), .RST_WCS(RST_WCS)
  ) u_desc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we),
    .sel_i (sel_i),
    .off_i (dst_i[OFF_W-1:0]),
    .wc_i  (src_i[OFF_W-1:0]),
    .off_o (cur_off),
    .wc_o  (cur_wc)
  );

  bfu_mask_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_mask (
    .off_i       (cur_off),
    .wc_i        (cur_wc),
    .width_o     (cur_width),
    .low_mask_o  (sel_low_mask),
    .field_mask_o(sel_field_mask)
  );

  bfu_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_dp (
    .op_i        (op_i),
    .dst_i       (dst_i),
    .src_i       (src_i),
    .off_i       (cur_off),
    .width_i     (cur_width),
    .low_mask_i  (sel_low_mask),
    .field_mask_i(sel_field_mask),
    .result_o    (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [DATA_W-1:0] low_mask,
  input logic [DATA_W-1:0] field_mask
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o))); // R2
  AST_CFG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=> (result_o == '0)); // R3
  AST_GET_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2) |=> ((result_o & ~$past(low_mask)) == '0)); // R5
  AST_SET_KEEPS_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1) |=> (((result_o ^ $past(dst_i)) & ~$past(field_mask)) == '0)); // R6
  AST_RSV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 3'd5) |=> (result_o == $past(dst_i))); // R11
endmodule

bind bitfield_unit bfu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .dst_i     (dst_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .low_mask  (sel_low_mask),
  .field_mask(sel_field_mask)
);

// File: tb/sim_bitfield_unit.sv
module sim_bitfield_unit;
  localparam int NV = 20;
  // {op, sel, dst, src, expected}
  localparam logic [99:0] VEC [NV] = '{
    {3'd2, 1'b0, 32'h00000000, 32'h12345678, 32'h00000078}, // R1 R5 reset A
    {3'd2, 1'b1, 32'h00000000, 32'h12345678, 32'h00000056}, // R1 R10 reset B
    {3'd1, 1'b0, 32'hFFFFFFFF, 32'h000000AB, 32'hFFFFFFAB}, // R6
    {3'd1, 1'b1, 32'h00000000, 32'h000001CD, 32'h0000CD00}, // R6
    {3'd0, 1'b0, 32'h00000004, 32'h00000003, 32'h00000000}, // R3 A=off4,w4
    {3'd2, 1'b0, 32'h00000000, 32'h000000F0, 32'h0000000F}, // R4
    {3'd2, 1'b1, 32'h00000000, 32'h0000AB00, 32'h000000AB}, // R10 B untouched
    {3'd0, 1'b1, 32'hFFFFFFFC, 32'h00000007, 32'h00000000}, // R3 B=off28,w8
    {3'd1, 1'b1, 32'h00000000, 32'h000000FF, 32'hF0000000}, // R7
    {3'd2, 1'b1, 32'h00000000, 32'hA0000000, 32'h0000000A}, // R7
    {3'd3, 1'b0, 32'h12345678, 32'h00000090, 32'h23456789}, // R8
    {3'd4, 1'b0, 32'h12345678, 32'h000000C0, 32'hC1234567}, // R9
    {3'd0, 1'b0, 32'h00000000, 32'h0000001F, 32'h00000000}, // R3 A=off0,w32
    {3'd2, 1'b0, 32'h00000000, 32'hDEADBEEF, 32'hDEADBEEF}, // R4
    {3'd3, 1'b0, 32'h11111111, 32'hCAFEF00D, 32'hCAFEF00D}, // R8
    {3'd0, 1'b0, 32'h0000001F, 32'h00000000, 32'h00000000}, // R3 A=off31,w1
    {3'd1, 1'b0, 32'h00000000, 32'h00000001, 32'h80000000}, // R4 R6
    {3'd4, 1'b0, 32'h00000002, 32'h80000000, 32'h80000001}, // R9
    {3'd5, 1'b0, 32'h5A5A5A5A, 32'h00000000, 32'h5A5A5A5A}, // R11
    {3'd2, 1'b0, 32'h00000000, 32'h80000000, 32'h00000001}  // R11 A intact
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        sel_i = 1'b0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitfield_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .sel_i(sel_i),
    .dst_i(dst_i), .src_i(src_i), .valid_o(valid_o), .result_o(result_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic sel,
                       input logic [31:0] d, input logic [31:0] s);
    valid_i = 1'b1; op_i = op; sel_i = sel; dst_i = d; src_i = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid_o in reset", {31'b0, valid_o}, 32'h0);
    chk("R1 result_o in reset", result_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result_o after reset", result_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:97], VEC[i][96], VEC[i][95:64], VEC[i][63:32]);
      chk($sformatf("vector %0d valid R2", i), {31'b0, valid_o}, 32'h1);
      chk($sformatf("vector %0d result", i), result_o, VEC[i][31:0]);
    end

    // R2: idle cycle holds result
    valid_i = 1'b0; dst_i = 32'hFFFF0000; src_i = 32'h0000FFFF; op_i = 3'd2;
    @(negedge clk);
    chk("R2 valid_o low when idle", {31'b0, valid_o}, 32'h0);
    chk("R2 result held", result_o, 32'h00000001);

    // R1: reset restores descriptor B after reconfiguration
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(3'd2, 1'b1, 32'h0, 32'h12345678);
    chk("R1 B restored by reset", result_o, 32'h00000056);
    apply(3'd3, 1'b1, 32'hAABBCCDD, 32'h00001200);
    chk("R8 rotate-left byte on B", result_o, 32'hBBCCDD12);
    apply(3'd7, 1'b1, 32'h0, 32'h00000003);
    chk("R11 opcode 7 passes dst", result_o, 32'h0);
    apply(3'd2, 1'b1, 32'h0, 32'h0000EE00);
    chk("R11 B intact after opcode 7", result_o, 32'h000000EE);
    valid_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule